// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is a bus slave on a two-wire I2C link. It gives an external master read and write access to a small internal register file. It samples SCL and SDA through a synchronizer, finds START, repeated START and STOP conditions, and matches a fixed 7-bit device address. A write transaction carries an index byte after the address. Bits 6..0 of that byte select the first register, and bit 7 turns on auto-increment of the register pointer for the rest of the transaction. Data bytes that follow are stored. A read transaction starts the same way, then switches direction with a repeated START and a read address. The slave then shifts out register contents until the master declines a byte.

SDA is never driven high. The block only asserts an output enable that pulls the wire low, and the surrounding pad makes it open-drain. The register file resets to a computed pattern. This gives a master, or a bench, known contents to read before any write.

Top module: `i2cs_regfile_slave`

## Requirements
- R1: While reset is asserted and right after it, `sda_oe_o` is low. Register i holds `INIT_XOR ^ i` (default `INIT_XOR` = 0xA5).
- R2: After an address byte whose upper 7 bits differ from `DEV_ADDR` (default 0x2A), the slave leaves SDA released in the acknowledge slot. It keeps SDA released for every later clock until the next START.
- R3: When the address byte's upper 7 bits equal `DEV_ADDR`, the slave pulls SDA low in the ninth clock of that byte. Bit 0 is the direction: 0 is write, 1 is read.
- R4: In a write, every byte is 8 bits, MSB first. The slave acknowledges the index byte and each data byte. Each data byte is stored in the register the pointer selects.
- R5: With index bit 7 set, successive written bytes go to successive registers. The pointer wraps from `DEPTH-1` to 0.
- R6: With index bit 7 clear, all written bytes of one transaction go to the same register, so the last byte written remains.
- R7: After the index byte, a repeated START and a matching read address, the slave drives the selected register MSB first. It drives a 1 bit by releasing SDA and a 0 bit by pulling it low.
- R8: In a read with index bit 7 set, each master acknowledge (SDA low in the ninth clock) makes the slave return the next register, wrapping modulo `DEPTH`.
- R9: In a read with index bit 7 clear, every byte returns the same register.
- R10: After a master not-acknowledge (SDA high in the ninth clock), the slave releases SDA and drives nothing until the next START.
- R11: A START or STOP that arrives in the middle of a byte discards the partial byte. A START restarts address matching, and a STOP returns the slave to idle.
- R12: `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock wire as seen at the pad |
| sda_i | input | 1 | Bus data wire as seen at the pad |
| sda_oe_o | output | 1 | High pulls SDA low; low releases it |

## Verification
The bench aims at the pointer behaviour at its edges. A burst write and a burst read both cross the last register. A design that saturated instead of wrapping would return the top register twice. A design that ignored the mode bit would spread a fixed-pointer write across neighbours and change a register that must stay intact. Interrupted transfers are also covered. A STOP four bits into a data byte must leave the register untouched, and a repeated START three bits into a byte must still lead to a clean acknowledged read. A design that kept its bit count would misframe the next address. A wrong address, and the clocks after a master not-acknowledge, are watched for any pull on SDA. A slave that acknowledged blindly or kept driving read data would show up there as an acknowledge or a stray low.

// File: rtl/i2cs_pkg.sv
`timescale 1ns/1ps
package i2cs_pkg;

   // Protocol phases of the slave controller
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_SUB,
      ST_SUB_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RDATA_ACK
   } i2cs_state_e;

   // One-cycle bus events derived from the synchronized wires
   typedef struct packed {
      logic scl_rise;
      logic scl_fall;
      logic sda;
      logic start;
      logic stop;
   } i2cs_bus_ev_t;

   localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/i2cs_line_sync.sv
`timescale 1ns/1ps
module i2cs_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2cs_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              last;

   // Idle bus level is high, so reset the chain to ones
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
         last  <= 1'b1;
      end else begin
         chain <= {chain[STAGES-2:0], line_i};
         last  <= chain[STAGES-1];
      end
   end

   assign level_o = chain[STAGES-1];
   assign rise_o  = chain[STAGES-1] & ~last;
   assign fall_o  = ~chain[STAGES-1] & last;

endmodule

// File: rtl/i2cs_bus_watch.sv
`timescale 1ns/1ps
module i2cs_bus_watch
   import i2cs_pkg::*;
#(
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         scl_i,
   input  logic         sda_i,
   output i2cs_bus_ev_t ev_o
);

   logic scl_lvl, scl_rise, scl_fall;
   logic sda_lvl, sda_rise, sda_fall;

   i2cs_line_sync #(.STAGES(STAGES)) u_scl (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (scl_i),
      .level_o(scl_lvl),
      .rise_o (scl_rise),
      .fall_o (scl_fall)
   );

   i2cs_line_sync #(.STAGES(STAGES)) u_sda (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (sda_i),
      .level_o(sda_lvl),
      .rise_o (sda_rise),
      .fall_o (sda_fall)
   );

   // SCL high in this and the previous sample: level set, no rise now
   logic scl_steady_hi;
   assign scl_steady_hi = scl_lvl & ~scl_rise;

   always_comb begin
      ev_o          = '0;
      ev_o.scl_rise = scl_rise;
      ev_o.scl_fall = scl_fall;
      ev_o.sda      = sda_lvl;
      ev_o.start    = scl_steady_hi & sda_fall;
      ev_o.stop     = scl_steady_hi & sda_rise;
   end

endmodule

// File: rtl/i2cs_regfile.sv
`timescale 1ns/1ps
module i2cs_regfile #(
   parameter int unsigned DEPTH    = 16,
   parameter int unsigned PTR_W    = 4,
   parameter logic [7:0]  INIT_XOR = 8'hA5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [PTR_W-1:0] addr,
   input  logic [7:0]       wdata,
   output logic [7:0]       rdata
);

   logic [7:0] rows [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_row
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= INIT_XOR ^ 8'(g);
         end else if (we && (addr == PTR_W'(g))) begin
            q <= wdata;
         end
      end
      assign rows[g] = q;
   end

   assign rdata = rows[addr];

endmodule

// File: rtl/i2cs_ctrl.sv
`timescale 1ns/1ps
module i2cs_ctrl
   import i2cs_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR = 7'h2A,
   parameter int unsigned PTR_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  i2cs_bus_ev_t     ev,
   input  logic [7:0]       rdata,
   output logic             we,
   output logic [7:0]       wdata,
   output logic [PTR_W-1:0] ptr,
   output logic             sda_oe,
   output i2cs_state_e      state_o,
   output logic [3:0]       cnt_o
);

   localparam logic [3:0] FULL = 4'(BYTE_W);

   i2cs_state_e state;
   logic [3:0]  cnt;
   logic [7:0]  sh;
   logic        rw;
   logic        inc;
   logic        mack;

   logic byte_done;
   logic framed;
   assign byte_done = ev.scl_fall && (cnt == FULL);
   assign framed    = !ev.start && !ev.stop;

   // Data byte lands in the register file on the falling edge that opens its ACK slot
   assign we    = framed && (state == ST_WDATA) && byte_done;
   assign wdata = sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         sh     <= '0;
         rw     <= 1'b0;
         inc    <= 1'b0;
         mack   <= 1'b0;
         ptr    <= '0;
         sda_oe <= 1'b0;
      end else if (ev.start) begin
         state  <= ST_ADDR;
         cnt    <= '0;
         sda_oe <= 1'b0;
      end else if (ev.stop) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         sda_oe <= 1'b0;
      end else begin
         unique case (state)
            ST_ADDR, ST_SUB, ST_WDATA: begin
               if (ev.scl_rise && (cnt < FULL)) begin
                  sh  <= {sh[6:0], ev.sda};
                  cnt <= cnt + 4'd1;
               end else if (byte_done) begin
                  cnt <= '0;
                  if (state == ST_ADDR) begin
                     if (sh[7:1] == DEV_ADDR) begin
                        rw     <= sh[0];
                        sda_oe <= 1'b1;
                        state  <= ST_ADDR_ACK;
                     end else begin
                        state  <= ST_IDLE;
                     end
                  end else if (state == ST_SUB) begin
                     inc    <= sh[7];
                     ptr    <= sh[PTR_W-1:0];
                     sda_oe <= 1'b1;
                     state  <= ST_SUB_ACK;
                  end else begin
                     sda_oe <= 1'b1;
                     state  <= ST_WDATA_ACK;
                  end
               end
            end
            ST_ADDR_ACK: begin
               if (ev.scl_fall) begin
                  cnt <= '0;
                  if (rw) begin
                     sh     <= rdata;
                     sda_oe <= ~rdata[7];
                     state  <= ST_RDATA;
                  end else begin
                     sda_oe <= 1'b0;
                     state  <= ST_SUB;
                  end
               end
            end
            ST_SUB_ACK: begin
               if (ev.scl_fall) begin
                  sda_oe <= 1'b0;
                  cnt    <= '0;
                  state  <= ST_WDATA;
               end
            end
            ST_WDATA_ACK: begin
               if (ev.scl_fall) begin
                  sda_oe <= 1'b0;
                  cnt    <= '0;
                  state  <= ST_WDATA;
                  if (inc) ptr <= ptr + 1'b1;
               end
            end
            ST_RDATA: begin
               if (ev.scl_rise && (cnt < FULL)) begin
                  cnt <= cnt + 4'd1;
               end else if (ev.scl_fall) begin
                  if (cnt == FULL) begin
                     sda_oe <= 1'b0;
                     cnt    <= '0;
                     state  <= ST_RDATA_ACK;
                     if (inc) ptr <= ptr + 1'b1;
                  end else begin
                     sh     <= {sh[6:0], 1'b0};
                     sda_oe <= ~sh[6];
                  end
               end
            end
            ST_RDATA_ACK: begin
               if (ev.scl_rise) begin
                  mack <= ~ev.sda;
               end else if (ev.scl_fall) begin
                  if (mack) begin
                     sh     <= rdata;
                     sda_oe <= ~rdata[7];
                     state  <= ST_RDATA;
                  end else begin
                     state  <= ST_IDLE;
                  end
               end
            end
            default: begin
               state <= ST_IDLE;
            end
         endcase
      end
   end

   assign state_o = state;
   assign cnt_o   = cnt;

endmodule

// File: rtl/i2cs_regfile_slave.sv
`timescale 1ns/1ps
module i2cs_regfile_slave
   import i2cs_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR    = 7'h2A,
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [7:0]  INIT_XOR    = 8'hA5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe_o
);

   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if ((DEPTH < 2) || (DEPTH > 128) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("i2cs_regfile_slave: DEPTH must be a power of two from 2 to 128");
   end

   i2cs_bus_ev_t     bus_ev;
   i2cs_state_e      ctrl_state;
   logic [3:0]       ctrl_cnt;
   logic             wr_en;
   logic [7:0]       wr_data;
   logic [7:0]       rd_data;
   logic [PTR_W-1:0] reg_ptr;

   i2cs_bus_watch #(.STAGES(SYNC_STAGES)) u_watch (
      .clk  (clk),
      .rst_n(rst_n),
      .scl_i(scl_i),
      .sda_i(sda_i),
      .ev_o (bus_ev)
   );

   i2cs_ctrl #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev     (bus_ev),
      .rdata  (rd_data),
      .we     (wr_en),
      .wdata  (wr_data),
      .ptr    (reg_ptr),
      .sda_oe (sda_oe_o),
      .state_o(ctrl_state),
      .cnt_o  (ctrl_cnt)
   );

   i2cs_regfile #(.DEPTH(DEPTH), .PTR_W(PTR_W), .INIT_XOR(INIT_XOR)) u_regs (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (wr_en),
      .addr (reg_ptr),
      .wdata(wr_data),
      .rdata(rd_data)
   );

endmodule

// File: rtl/i2cs_checker.sv
`timescale 1ns/1ps
module i2cs_checker
   import i2cs_pkg::*;
(
   input logic         clk,
   input logic         rst_n,
   input i2cs_bus_ev_t ev,
   input i2cs_state_e  state,
   input logic [3:0]   cnt,
   input logic         we,
   input logic         sda_oe
);

   // Tracks the synchronized SCL level from its edge events
   logic scl_hi;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           scl_hi <= 1'b1;
      else if (ev.scl_rise) scl_hi <= 1'b1;
      else if (ev.scl_fall) scl_hi <= 1'b0;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_RELEASED: assert (!sda_oe); // R1
      end
   end

   AST_ADDR_ACK_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ADDR_ACK) |-> sda_oe); // R3

   AST_WRITE_THEN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> ((state == ST_WDATA_ACK) && sda_oe)); // R4

   AST_BYTE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= 4'd8); // R7

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe); // R10

   AST_START_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
      ev.start |=> ((state == ST_ADDR) && (cnt == 4'd0))); // R11

   AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      ev.stop |=> (state == ST_IDLE)); // R11

   AST_OE_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      scl_hi |-> $stable(sda_oe)); // R12

endmodule

bind i2cs_regfile_slave i2cs_checker u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .ev    (bus_ev),
   .state (ctrl_state),
   .cnt   (ctrl_cnt),
   .we    (wr_en),
   .sda_oe(sda_oe_o)
);

// File: tb/i2cs_regfile_slave_test.sv
`timescale 1ns/1ps
module i2cs_regfile_slave_test;

   localparam logic [6:0] DEV   = 7'h2A;
   localparam int         DEPTH = 16;
   localparam int         Q     = 8;

   logic clk   = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic scl_m     = 1'b1;
   logic sda_m_low = 1'b0;
   wire  sda_oe;
   wire  sda_line = ~(sda_m_low | sda_oe);

   i2cs_regfile_slave uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_i   (scl_m),
      .sda_i   (sda_line),
      .sda_oe_o(sda_oe)
   );

   int vectors     = 0;
   int miscompares = 0;
   logic [7:0] mdl [DEPTH];

   // Scoreboard queues
   string      req_q [$];
   logic [7:0] exp_q [$];
   logic [7:0] got_q [$];
   event       byte_ev;

   int   oe_hi_chg  = 0;
   int   quiet_hits = 0;
   logic quiet_win  = 1'b0;

   always @(sda_oe) if (rst_n && scl_m) oe_hi_chg++;
   always @(negedge clk) if (quiet_win && sda_oe) quiet_hits++;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic expect_byte(input string req, input logic [7:0] v);
      req_q.push_back(req);
      exp_q.push_back(v);
   endtask

   // Monitor: pops one expectation per captured read byte
   initial begin
      forever begin
         @(byte_ev);
         while (got_q.size() > 0) begin
            logic [7:0] g;
            g = got_q.pop_front();
            if (exp_q.size() == 0) begin
               check("R7", {24'd0, g}, 32'hFFFF_FFFF);
            end else begin
               string      r;
               logic [7:0] e;
               r = req_q.pop_front();
               e = exp_q.pop_front();
               check(r, {24'd0, g}, {24'd0, e});
            end
         end
      end
   end

   task automatic tick();
      repeat (Q) @(negedge clk);
   endtask

   task automatic i2c_start();
      sda_m_low = 1'b0; scl_m = 1'b1; tick();
      sda_m_low = 1'b1; tick();
      scl_m = 1'b0; tick();
   endtask

   task automatic i2c_rstart();
      sda_m_low = 1'b0; tick();
      scl_m = 1'b1; tick();
      sda_m_low = 1'b1; tick();
      scl_m = 1'b0; tick();
   endtask

   task automatic i2c_stop();
      sda_m_low = 1'b1; tick();
      scl_m = 1'b1; tick();
      sda_m_low = 1'b0; tick();
   endtask

   task automatic wbit(input logic b);
      sda_m_low = ~b; tick();
      scl_m = 1'b1; tick(); tick();
      scl_m = 1'b0; tick();
   endtask

   task automatic rbit(output logic b);
      sda_m_low = 1'b0; tick();
      scl_m = 1'b1; tick();
      b = sda_line; tick();
      scl_m = 1'b0; tick();
   endtask

   task automatic wbyte(input logic [7:0] d, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) wbit(d[i]);
      rbit(b);
      ack = ~b;
   endtask

   task automatic rbyte(input logic mack);
      logic [7:0] d;
      logic       b;
      d = '0;
      for (int i = 0; i < 8; i++) begin
         rbit(b);
         d = {d[6:0], b};
      end
      wbit(~mack);
      got_q.push_back(d);
      ->byte_ev;
   endtask

   task automatic do_write(input string req, input logic inc, input logic [6:0] idx0,
                           input logic [7:0] d [4], input int n);
      logic ack;
      int   idx;
      i2c_start();
      wbyte({DEV, 1'b0}, ack); check("R3", {31'd0, ack}, 1);
      wbyte({inc, idx0}, ack); check(req, {31'd0, ack}, 1);
      idx = int'(idx0) % DEPTH;
      for (int i = 0; i < n; i++) begin
         wbyte(d[i], ack); check(req, {31'd0, ack}, 1);
         mdl[idx] = d[i];
         if (inc) idx = (idx + 1) % DEPTH;
      end
      i2c_stop();
   endtask

   task automatic do_read(input string req, input logic inc, input logic [6:0] idx0, input int n);
      logic ack;
      int   idx;
      i2c_start();
      wbyte({DEV, 1'b0}, ack); check("R3", {31'd0, ack}, 1);
      wbyte({inc, idx0}, ack); check(req, {31'd0, ack}, 1);
      i2c_rstart();
      wbyte({DEV, 1'b1}, ack); check("R3", {31'd0, ack}, 1);
      idx = int'(idx0) % DEPTH;
      for (int i = 0; i < n; i++) begin
         expect_byte(req, mdl[idx]);
         rbyte(i < n - 1);
         if (inc) idx = (idx + 1) % DEPTH;
      end
      i2c_stop();
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic ack;
      for (int i = 0; i < DEPTH; i++) mdl[i] = 8'hA5 ^ 8'(i);
      repeat (5) @(negedge clk);
      check("R1", {31'd0, sda_oe}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R1", {31'd0, sda_oe}, 0);

      // R1 / R7: reset contents, including a wrap at the top register
      do_read("R7", 1'b0, 7'd3, 1);
      do_read("R1", 1'b1, 7'd15, 2);

      // R2: foreign address is never acknowledged, nothing driven afterwards
      i2c_start();
      quiet_win = 1'b1;
      wbyte({7'h2B, 1'b0}, ack); check("R2", {31'd0, ack}, 0);
      wbyte(8'h00, ack);         check("R2", {31'd0, ack}, 0);
      quiet_win = 1'b0;
      i2c_stop();
      check("R2", quiet_hits, 0);

      // R4: single byte write and read back
      do_write("R4", 1'b0, 7'd5, '{8'h3C, 8'h00, 8'h00, 8'h00}, 1);
      do_read("R4", 1'b0, 7'd5, 1);

      // R5 / R8: burst across the top of the file
      do_write("R5", 1'b1, 7'd14, '{8'h11, 8'h22, 8'h33, 8'h44}, 4);
      do_read("R5", 1'b1, 7'd14, 4);
      do_read("R8", 1'b1, 7'd13, 4);

      // R6: fixed pointer write, neighbour untouched
      do_write("R6", 1'b0, 7'd7, '{8'h55, 8'h66, 8'h77, 8'h00}, 3);
      do_read("R6", 1'b1, 7'd7, 2);

      // R9: fixed pointer read repeats one register
      do_read("R9", 1'b0, 7'd14, 3);

      // R10: after master NACK the slave stays off the wire
      i2c_start();
      wbyte({DEV, 1'b0}, ack); check("R3", {31'd0, ack}, 1);
      wbyte({1'b1, 7'd0}, ack); check("R10", {31'd0, ack}, 1);
      i2c_rstart();
      wbyte({DEV, 1'b1}, ack); check("R3", {31'd0, ack}, 1);
      expect_byte("R10", mdl[0]);
      rbyte(1'b0);
      quiet_win = 1'b1;
      wbyte(8'h00, ack); check("R10", {31'd0, ack}, 0);
      quiet_win = 1'b0;
      i2c_stop();
      check("R10", quiet_hits, 0);

      // R11: STOP mid byte discards it
      i2c_start();
      wbyte({DEV, 1'b0}, ack); check("R3", {31'd0, ack}, 1);
      wbyte({1'b0, 7'd4}, ack); check("R11", {31'd0, ack}, 1);
      for (int i = 0; i < 4; i++) wbit(1'b0);
      i2c_stop();
      do_read("R11", 1'b0, 7'd4, 1);

      // R11: repeated START mid byte reframes address matching
      i2c_start();
      wbyte({DEV, 1'b0}, ack); check("R3", {31'd0, ack}, 1);
      wbyte({1'b0, 7'd9}, ack); check("R11", {31'd0, ack}, 1);
      for (int i = 0; i < 3; i++) wbit(1'b1);
      i2c_rstart();
      wbyte({DEV, 1'b1}, ack); check("R11", {31'd0, ack}, 1);
      expect_byte("R11", mdl[9]);
      rbyte(1'b0);
      i2c_stop();

      repeat (20) @(negedge clk);
      check("R12", oe_hi_chg, 0);
      check("R7", exp_q.size(), 0);
      summary();
      $finish;
   end

endmodule